// File: doc/BRIEF.md
# Windowed Display-Memory Address Generator

This block produces the write address for a 240 by 320 pixel display memory, limited to a rectangle that the host sets through a small register port. Four window registers hold the left and right column bounds (8 bits each) and the top and bottom row bounds (9 bits each). Every pixel-write strobe moves the current position one column to the right. At the right edge of the window the position returns to the left column of the next row. After the bottom-right corner it returns to the top-left corner, so writes never leave the rectangle.

Any write to a window register places the position at the top-left corner of the window. A bound set that breaks the ordering or range rules raises an error flag. While the flag is high, the position covers the whole panel instead of the window. The column, the row and a flat address (row times 240 plus column) are driven out for the memory.

Top module: `windowed_gram_addr`

## Requirements
- R1: During and after a synchronous active-low reset, the column, row and flat address outputs are 0 and the error flag is 0. The window registers reset to left 0, right 239, top 0 and bottom 319.
- R2: When `reg_wr` is high, the register index selects the bound to load. Index 0x50 loads the left column, 0x51 the right column, 0x52 the top row and 0x53 the bottom row. Column bounds take data bits [7:0] and row bounds take data bits [8:0]; the upper data bits are ignored.
- R3: A register write to any other index changes no bound and does not move the position.
- R4: A strobe on `pix_wr` raises the column by one. When the column equals the right bound, the strobe sets the column to the left bound and raises the row by one.
- R5: A strobe taken while the position is at the right bound and the bottom bound moves it to the left bound and the top bound.
- R6: After the clock edge that takes a window register write, the position reads as the top-left corner of the new window at the second rising edge. A strobe presented in the cycle between those two edges is dropped.
- R7: From the first edge after a write, the error flag is 1 exactly when left >= right, right > 239, top >= bottom, or bottom > 319. Otherwise it is 0.
- R8: While the error flag is 1, the position moves inside columns 0 to 239 and rows 0 to 319, starting from 0,0 after the reload.
- R9: The flat address always equals row times 240 plus column, and it reaches 76799 at the last pixel of the full panel.
- R10: When there is no strobe and no reload, the column and row keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write enable |
| reg_idx | input | 8 | Register index |
| reg_data | input | 16 | Register write data |
| pix_wr | input | 1 | Pixel-write strobe, advances the position |
| h_addr | output | 8 | Current column |
| v_addr | output | 9 | Current row |
| lin_addr | output | 17 | Flat address, row times 240 plus column |
| win_err | output | 1 | Window bounds are illegal; full panel in use |

## Verification
The assertions assume that the position only changes through a strobe or a reload. They also assume that every change of the bounds is followed by a reload pulse, so the window-containment check is waived only in that reload cycle. The stimulus always uses the register port to change bounds and never forces the position. It keeps the bound registers legal except in the deliberate error cases, where the model switches to full-panel bounds. A strobe is placed in the reload cycle only in the single case built to show that it is dropped.

// File: rtl/win_addr_pkg.sv
// Shared types for the windowed address generator.
// Assumes the four window registers sit at four consecutive indices.
package win_addr_pkg;
    // Offset of a window register from the register base.
    // The decode depends on this order.
    typedef enum logic [1:0] {
        SEL_HS = 2'd0,
        SEL_HE = 2'd1,
        SEL_VS = 2'd2,
        SEL_VE = 2'd3
    } win_sel_e;
endpackage

// File: rtl/win_regs.sv
// Window bound registers with index decode.
// Loads one bound per register write and emits a one-cycle reload pulse
// on the edge after any write that hits the window range.
// Assumes REG_BASE is a multiple of 4 and DATA_W > V_W >= H_W.
module win_regs
    import win_addr_pkg::*;
#(
    parameter int H_W      = 8,
    parameter int V_W      = 9,
    parameter int IDX_W    = 8,
    parameter int DATA_W   = 16,
    parameter int REG_BASE = 'h50,
    parameter int H_MAX    = 239,
    parameter int V_MAX    = 319
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0] reg_data,
    output logic [H_W-1:0]    hs,
    output logic [H_W-1:0]    he,
    output logic [V_W-1:0]    vs,
    output logic [V_W-1:0]    ve,
    output logic              reload_q
);
    localparam logic [IDX_W-1:0] BASE = IDX_W'(REG_BASE);

    logic     hit;
    win_sel_e sel;
    logic     unused_data_hi;

    // Decode a write to one of the four window registers.
    always_comb begin
        hit = reg_wr && (reg_idx[IDX_W-1:2] == BASE[IDX_W-1:2]);
        sel = win_sel_e'(reg_idx[1:0]);
    end

    assign unused_data_hi = ^reg_data[DATA_W-1:V_W];

    // Hold the bounds; reset to the full panel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs <= '0;
            he <= H_W'(H_MAX);
            vs <= '0;
            ve <= V_W'(V_MAX);
        end else if (hit) begin
            case (sel)
                SEL_HS: hs <= reg_data[H_W-1:0];
                SEL_HE: he <= reg_data[H_W-1:0];
                SEL_VS: vs <= reg_data[V_W-1:0];
                SEL_VE: ve <= reg_data[V_W-1:0];
                default: ;
            endcase
        end
    end

    // Register the reload request so it sees the updated bounds.
    always_ff @(posedge clk) begin
        if (!rst_n) reload_q <= 1'b0;
        else        reload_q <= hit;
    end
endmodule

// File: rtl/win_check.sv
// Bound legality check and selection of the bounds in effect.
// Illegal bounds raise err and fall back to the whole panel.
// Purely combinational; assumes H_MAX and V_MAX fit in H_W and V_W bits.
module win_check #(
    parameter int H_W   = 8,
    parameter int V_W   = 9,
    parameter int H_MAX = 239,
    parameter int V_MAX = 319
) (
    input  logic [H_W-1:0] hs,
    input  logic [H_W-1:0] he,
    input  logic [V_W-1:0] vs,
    input  logic [V_W-1:0] ve,
    output logic           err,
    output logic [H_W-1:0] hs_eff,
    output logic [H_W-1:0] he_eff,
    output logic [V_W-1:0] vs_eff,
    output logic [V_W-1:0] ve_eff
);
    localparam logic [H_W-1:0] H_LAST = H_W'(H_MAX);
    localparam logic [V_W-1:0] V_LAST = V_W'(V_MAX);

    // Flag bounds out of order or beyond the panel edge.
    always_comb begin
        err = (hs >= he) || (he > H_LAST) || (vs >= ve) || (ve > V_LAST);
    end

    // Select the programmed window or the full-panel fallback.
    always_comb begin
        if (err) begin
            hs_eff = '0;
            he_eff = H_LAST;
            vs_eff = '0;
            ve_eff = V_LAST;
        end else begin
            hs_eff = hs;
            he_eff = he;
            vs_eff = vs;
            ve_eff = ve;
        end
    end
endmodule

// File: rtl/win_cursor.sv
// Current column and row inside the window in effect.
// A reload wins over a strobe. Assumes the position is inside the bounds
// whenever a strobe is taken; the >= compares keep it bounded anyway.
module win_cursor #(
    parameter int H_W = 8,
    parameter int V_W = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reload,
    input  logic           step,
    input  logic [H_W-1:0] hs_eff,
    input  logic [H_W-1:0] he_eff,
    input  logic [V_W-1:0] vs_eff,
    input  logic [V_W-1:0] ve_eff,
    output logic [H_W-1:0] h_cur,
    output logic [V_W-1:0] v_cur
);
    logic row_end;
    logic col_end;

    // Detect the right and bottom edges.
    always_comb begin
        col_end = (h_cur >= he_eff);
        row_end = (v_cur >= ve_eff);
    end

    // Move the position: reload to top-left, or step with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_cur <= '0;
            v_cur <= '0;
        end else if (reload) begin
            h_cur <= hs_eff;
            v_cur <= vs_eff;
        end else if (step) begin
            if (col_end) begin
                h_cur <= hs_eff;
                v_cur <= row_end ? vs_eff : v_cur + 1'b1;
            end else begin
                h_cur <= h_cur + 1'b1;
            end
        end
    end
endmodule

// File: rtl/win_linear.sv
// Flat address from column and row: row * ROW_LEN + column.
// Combinational; assumes LIN_W holds ROW_LEN * rows.
module win_linear #(
    parameter int H_W     = 8,
    parameter int V_W     = 9,
    parameter int ROW_LEN = 240,
    parameter int LIN_W   = 17
) (
    input  logic [H_W-1:0]   h_cur,
    input  logic [V_W-1:0]   v_cur,
    output logic [LIN_W-1:0] lin
);
    localparam logic [LIN_W-1:0] ROW_K = LIN_W'(ROW_LEN);

    // Multiply by the constant row length and add the column.
    always_comb begin
        lin = LIN_W'(v_cur) * ROW_K + LIN_W'(h_cur);
    end
endmodule

// File: rtl/windowed_gram_addr.sv
// Windowed display-memory write address generator (top).
// The register port programs a rectangle. Each pixel strobe walks it in
// row-major order and wraps inside it. Illegal bounds fall back to the
// whole panel and raise win_err.
// Assumes a single clock domain and a synchronous active-low reset.
module windowed_gram_addr #(
    parameter int H_W      = 8,
    parameter int V_W      = 9,
    parameter int IDX_W    = 8,
    parameter int DATA_W   = 16,
    parameter int REG_BASE = 'h50,
    parameter int H_MAX    = 239,
    parameter int V_MAX    = 319,
    parameter int LIN_W    = $clog2((H_MAX + 1) * (V_MAX + 1))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0] reg_data,
    input  logic              pix_wr,
    output logic [H_W-1:0]    h_addr,
    output logic [V_W-1:0]    v_addr,
    output logic [LIN_W-1:0]  lin_addr,
    output logic              win_err
);
    logic [H_W-1:0] hs, he, hs_eff, he_eff;
    logic [V_W-1:0] vs, ve, vs_eff, ve_eff;
    logic           reload_q;

    win_regs #(
        .H_W(H_W), .V_W(V_W), .IDX_W(IDX_W), .DATA_W(DATA_W),
        .REG_BASE(REG_BASE), .H_MAX(H_MAX), .V_MAX(V_MAX)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_data(reg_data), .hs(hs), .he(he), .vs(vs), .ve(ve),
        .reload_q(reload_q)
    );

    win_check #(
        .H_W(H_W), .V_W(V_W), .H_MAX(H_MAX), .V_MAX(V_MAX)
    ) u_check (
        .hs(hs), .he(he), .vs(vs), .ve(ve), .err(win_err),
        .hs_eff(hs_eff), .he_eff(he_eff), .vs_eff(vs_eff), .ve_eff(ve_eff)
    );

    win_cursor #(
        .H_W(H_W), .V_W(V_W)
    ) u_cursor (
        .clk(clk), .rst_n(rst_n), .reload(reload_q), .step(pix_wr),
        .hs_eff(hs_eff), .he_eff(he_eff), .vs_eff(vs_eff), .ve_eff(ve_eff),
        .h_cur(h_addr), .v_cur(v_addr)
    );

    win_linear #(
        .H_W(H_W), .V_W(V_W), .ROW_LEN(H_MAX + 1), .LIN_W(LIN_W)
    ) u_linear (
        .h_cur(h_addr), .v_cur(v_addr), .lin(lin_addr)
    );
endmodule

// File: rtl/windowed_gram_addr_chk.sv
// Property checker for windowed_gram_addr, attached with bind below.
// Observes the ports plus the reload pulse and the bounds in effect.
module windowed_gram_addr_chk #(
    parameter int H_W   = 8,
    parameter int V_W   = 9,
    parameter int H_MAX = 239,
    parameter int V_MAX = 319,
    parameter int LIN_W = 17
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pix_wr,
    input logic             reload_q,
    input logic [H_W-1:0]   hs_eff,
    input logic [H_W-1:0]   he_eff,
    input logic [V_W-1:0]   vs_eff,
    input logic [V_W-1:0]   ve_eff,
    input logic [H_W-1:0]   h_addr,
    input logic [V_W-1:0]   v_addr,
    input logic [LIN_W-1:0] lin_addr
);
    localparam int PIXELS = (H_MAX + 1) * (V_MAX + 1);

    p_col_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_wr && !reload_q) |=> (h_addr == (($past(h_addr) >= $past(he_eff))
            ? $past(hs_eff) : $past(h_addr) + 1'b1)));

    p_row_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_wr && !reload_q && (h_addr < he_eff)) |=> $stable(v_addr));

    p_row_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_wr && !reload_q && (h_addr >= he_eff)) |=>
            (v_addr == (($past(v_addr) >= $past(ve_eff))
                ? $past(vs_eff) : $past(v_addr) + 1'b1)));

    p_reload_corner_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reload_q |=> (h_addr == $past(hs_eff) && v_addr == $past(vs_eff)));

    p_inside_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !reload_q |-> (h_addr >= hs_eff && h_addr <= he_eff &&
                       v_addr >= vs_eff && v_addr <= ve_eff));

    p_lin_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        int'(lin_addr) < PIXELS);

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_wr && !reload_q) |=> ($stable(h_addr) && $stable(v_addr)));
endmodule

bind windowed_gram_addr windowed_gram_addr_chk #(
    .H_W(H_W), .V_W(V_W), .H_MAX(H_MAX), .V_MAX(V_MAX), .LIN_W(LIN_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pix_wr(pix_wr), .reload_q(reload_q),
    .hs_eff(hs_eff), .he_eff(he_eff), .vs_eff(vs_eff), .ve_eff(ve_eff),
    .h_addr(h_addr), .v_addr(v_addr), .lin_addr(lin_addr)
);

// File: tb/windowed_gram_addr_bench.sv
`timescale 1ns/1ps
module windowed_gram_addr_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_idx = '0;
    logic [15:0] reg_data = '0;
    logic        pix_wr = 1'b0;
    logic [7:0]  h_addr;
    logic [8:0]  v_addr;
    logic [16:0] lin_addr;
    logic        win_err;

    always #10 clk = ~clk;

    windowed_gram_addr u_windowed_gram_addr (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_data(reg_data), .pix_wr(pix_wr), .h_addr(h_addr),
        .v_addr(v_addr), .lin_addr(lin_addr), .win_err(win_err)
    );

    typedef struct {
        int    h;
        int    v;
        bit    err;
        string tag;
    } exp_t;

    exp_t sb[$];
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;

    // Reference model state, taken from the requirements
    int m_hs = 0, m_he = 239, m_vs = 0, m_ve = 319;
    int m_h = 0, m_v = 0;
    bit m_err = 1'b0;

    task automatic check(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic void model_err();
        m_err = (m_hs >= m_he) || (m_he > 239) || (m_vs >= m_ve) || (m_ve > 319);
    endfunction

    function automatic void model_step();
        int e_hs = m_err ? 0 : m_hs;
        int e_he = m_err ? 239 : m_he;
        int e_vs = m_err ? 0 : m_vs;
        int e_ve = m_err ? 319 : m_ve;
        if (m_h >= e_he) begin
            m_h = e_hs;
            m_v = (m_v >= e_ve) ? e_vs : m_v + 1;
        end else begin
            m_h = m_h + 1;
        end
    endfunction

    function automatic void push(string tag);
        exp_t e;
        e.h = m_h; e.v = m_v; e.err = m_err; e.tag = tag;
        sb.push_back(e);
    endfunction

    // Driver: one pixel strobe; expected position is queued after the edge
    task automatic pix(string tag);
        @(negedge clk);
        reg_wr = 1'b0;
        pix_wr = 1'b1;
        @(posedge clk);
        #1;
        model_step();
        push(tag);
    endtask

    // Driver: one idle cycle (R10)
    task automatic idle(string tag);
        @(negedge clk);
        reg_wr = 1'b0;
        pix_wr = 1'b0;
        @(posedge clk);
        #1;
        push(tag);
    endtask

    // Driver: register write; optional strobe in the reload cycle (R6)
    task automatic wr(int idx, int data, bit strobe_after, string tag);
        bit in_map = (idx >= 'h50) && (idx <= 'h53);
        @(negedge clk);
        pix_wr = 1'b0;
        reg_wr = 1'b1;
        reg_idx = 8'(idx);
        reg_data = 16'(data);
        @(negedge clk);
        reg_wr = 1'b0;
        pix_wr = strobe_after;
        if (in_map) begin
            case (idx)
                'h50: m_hs = data & 'hFF;
                'h51: m_he = data & 'hFF;
                'h52: m_vs = data & 'h1FF;
                default: m_ve = data & 'h1FF;
            endcase
            model_err();
            m_h = m_err ? 0 : m_hs;
            m_v = m_err ? 0 : m_vs;
        end else if (strobe_after) begin
            model_step();
        end
        @(posedge clk);
        #1;
        push(tag);
    endtask

    // Monitor: pop and compare after each rising edge
    always @(negedge clk) begin
        exp_t e;
        if (sb.size() > 0) begin
            e = sb.pop_front();
            check(e.tag, "h_addr", int'(h_addr), e.h);
            check(e.tag, "v_addr", int'(v_addr), e.v);
            check(e.tag, "lin_addr", int'(lin_addr), e.v * 240 + e.h);
            check(e.tag, "win_err", int'(win_err), int'(e.err));
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "h_addr in reset", int'(h_addr), 0);
        check("R1", "v_addr in reset", int'(v_addr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "h_addr", int'(h_addr), 0);
        check("R1", "v_addr", int'(v_addr), 0);
        check("R1", "lin_addr", int'(lin_addr), 0);
        check("R1", "win_err", int'(win_err), 0);

        // R4: steps in the default full window
        for (int i = 0; i < 5; i++) pix("R4");
        // R10: hold without strobes
        for (int i = 0; i < 3; i++) idle("R10");

        // R2: program a 4x3 window; upper data bits are set and ignored
        wr('h50, 'hFF0A, 1'b0, "R2");
        wr('h51, 'hA40D, 1'b0, "R2");
        wr('h52, 'hFE05, 1'b0, "R2");
        wr('h53, 'h7C07, 1'b0, "R6");

        // R4/R5: walk the window and wrap to the corner
        for (int i = 0; i < 12; i++) pix("R4");
        for (int i = 0; i < 3; i++) pix("R5");
        pix("R5");

        // R3: writes outside the register range leave position and bounds
        wr('h54, 'h0001, 1'b0, "R3");
        wr('h4F, 'h0001, 1'b0, "R3");
        for (int i = 0; i < 4; i++) pix("R3");

        // R6: strobe in the reload cycle is dropped
        wr('h51, 'h000D, 1'b1, "R6");
        pix("R6");

        // R7/R8: right bound below left bound -> error and full panel
        wr('h51, 'h0005, 1'b0, "R7");
        for (int i = 0; i < 241; i++) pix("R8");
        // R7: fix it, error clears
        wr('h51, 'h0014, 1'b0, "R7");
        // R7: bottom bound beyond last row
        wr('h53, 'h0140, 1'b0, "R7");
        wr('h53, 'h0007, 1'b0, "R7");
        // R7: top equal to bottom
        wr('h52, 'h0007, 1'b0, "R7");
        wr('h52, 'h0005, 1'b0, "R7");

        // R9/R5: full-panel walk up to the last pixel and the wrap
        wr('h50, 'h0000, 1'b0, "R2");
        wr('h51, 'h00EF, 1'b0, "R2");
        wr('h52, 'h0000, 1'b0, "R2");
        wr('h53, 'h013F, 1'b0, "R2");
        for (int i = 0; i < 76799; i++) pix("R9");
        pix("R5");

        idle("R10");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule